// File: doc/BRIEF.md
# Trimmed Seconds Prescaler with Square-Wave Tap

This block turns a free-running 32.768 kHz input clock into a one-second timebase. A binary prescaler counts input cycles. A modulo-60 seconds counter follows it and marks the start of every minute. A signed digital trim corrects a slow or fast source. It is sampled on each minute boundary and applied there as a whole number of input cycles, twice the programmed magnitude. A positive trim freezes the prescaler for that many cycles. A negative trim starts the next second part-way through its count. Only the first second of each minute is lengthened or shortened.

A square-wave pin shows the timebase outside the chip. It carries a 1 Hz tap, one of two fast divided taps, or the raw input clock. The raw clock is never trimmed. The pin is held low unless it is enabled, and it is always held low while the device runs from its backup supply.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: After reset the prescaler and seconds count are zero, both ticks are low, and the first `sec_tick` comes DIV input cycles after reset is released (DIV = 2**PRE_W).
- R2: Away from a minute boundary, `sec_tick` pulses high for exactly one cycle every DIV input cycles.
- R3: `min_tick` pulses together with every SECS-th `sec_tick` and never on its own. The seconds count stays below SECS.
- R4: With `trim_neg` = 0, the second that begins at a minute boundary lasts DIV + 2*`trim_mag` input cycles.
- R5: With `trim_neg` = 1, the second that begins at a minute boundary lasts DIV - 2*`trim_mag` input cycles.
- R6: A `trim_mag` of zero leaves every second at DIV cycles, whatever the value of `trim_neg`.
- R7: `trim_mag` and `trim_neg` are sampled only on a minute boundary. A change made within a minute first acts at the next boundary.
- R8: With `rate_sel[2]` = 0, `rate_sel[1:0]` selects the tap. Code 00 gives the 1 Hz tap, which is low for the first half of each second and rises when the prescaler reaches DIV/2. Code 01 gives a tap with a period of 8 input cycles, and code 10 gives a tap with a period of 4 input cycles.
- R9: `rate_sel` = 011 passes the input clock to `wave_out` unchanged, and the trim never alters it.
- R10: With a positive trim, the divided taps are held for 2*`trim_mag` cycles at the minute boundary. Code 01 then rises 2*`trim_mag`+4 cycles after the boundary, and code 00 rises 2*`trim_mag`+DIV/2 cycles after it. With a negative trim, code 00 rises DIV/2-2*`trim_mag` cycles after the boundary.
- R11: `wave_out` is low whenever `wave_en` = 0, `on_battery` = 1 or `rate_sel[2]` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock (nominally 32.768 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| trim_mag | input | TRIM_W | Trim magnitude, in units of two input cycles |
| trim_neg | input | 1 | Trim sign: 1 removes cycles, 0 adds them |
| rate_sel | input | 3 | Square-wave source select |
| wave_en | input | 1 | Square-wave output enable |
| on_battery | input | 1 | Backup-supply mode, forces the pin low |
| wave_out | output | 1 | Square-wave pin |
| sec_tick | output | 1 | One-cycle pulse at the start of each second |
| min_tick | output | 1 | One-cycle pulse at the start of each minute |

## Verification
The assertions assume that the trim inputs change only between clock edges and that 2*`trim_mag` stays below DIV. The elaboration check guarantees the second condition for every trim value the port can carry. They also assume that `rate_sel`, `wave_en` and `on_battery` are steady at each sampling edge. The bench drives every input on a falling edge, and it changes the trim just after a minute tick, so each new value gets a full minute before it is sampled. The bench uses a small prescaler and a four-second minute, which keeps the largest trim below half a second.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
   typedef enum logic [1:0] {
      RATE_SECOND = 2'b00,
      RATE_SLOW   = 2'b01,
      RATE_FAST   = 2'b10,
      RATE_RAW    = 2'b11
   } rate_e;
endpackage

// File: rtl/rtcp_prescaler.sv
module rtcp_prescaler #(
   parameter int PRE_W  = 15,
   parameter int TRIM_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              min_edge,
   input  logic [TRIM_W-1:0] trim_mag,
   input  logic              trim_neg,
   output logic [PRE_W-1:0]  pre_q,
   output logic [TRIM_W:0]   frz_q,
   output logic              wrap
);
   localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

   logic [TRIM_W:0] trim_x2;
   assign trim_x2 = {trim_mag, 1'b0};
   assign wrap    = (pre_q == PRE_MAX) && (frz_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         frz_q <= '0;
      end else if (frz_q != '0) begin
         frz_q <= frz_q - 1'b1;
      end else if (wrap) begin
         if (min_edge && trim_neg) begin
            pre_q <= PRE_W'(trim_x2);
         end else if (min_edge) begin
            pre_q <= '0;
            frz_q <= trim_x2;
         end else begin
            pre_q <= '0;
         end
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtcp_sec_counter.sv
module rtcp_sec_counter #(
   parameter int SECS = 60,
   localparam int SEC_W = (SECS > 1) ? $clog2(SECS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [SEC_W-1:0] sec_q,
   output logic             at_last
);
   localparam logic [SEC_W-1:0] LAST = SEC_W'(SECS - 1);

   assign at_last = (sec_q == LAST);

   generate
      if ((1 << SEC_W) == SECS) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sec_q <= '0;
            else if (adv) sec_q <= sec_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sec_q <= '0;
            else if (adv) sec_q <= at_last ? '0 : sec_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rtcp_wave_sel.sv
module rtcp_wave_sel (
   input  logic       clk,
   input  logic       tap_second,
   input  logic       tap_slow,
   input  logic       tap_fast,
   input  logic [2:0] rate_sel,
   input  logic       wave_en,
   input  logic       on_battery,
   output logic       wave_out
);
   import rtcp_pkg::*;

   rate_e rate;
   logic  src;
   logic  open;

   assign rate = rate_e'(rate_sel[1:0]);
   assign open = wave_en && !on_battery && !rate_sel[2];

   always_comb begin
      unique case (rate)
         RATE_SECOND: src = tap_second;
         RATE_SLOW:   src = tap_slow;
         RATE_FAST:   src = tap_fast;
         RATE_RAW:    src = clk;
         default:     src = 1'b0;
      endcase
   end

   assign wave_out = open ? src : 1'b0;
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
   parameter int PRE_W    = 15,
   parameter int SECS     = 60,
   parameter int TRIM_W   = 8,
   parameter int SLOW_BIT = 2,
   parameter int FAST_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIM_W-1:0] trim_mag,
   input  logic              trim_neg,
   input  logic [2:0]        rate_sel,
   input  logic              wave_en,
   input  logic              on_battery,
   output logic              wave_out,
   output logic              sec_tick,
   output logic              min_tick
);
   localparam int SEC_W = (SECS > 1) ? $clog2(SECS) : 1;

   generate
      if (PRE_W <= TRIM_W + 1) begin : g_bad_trim
         $error("PRE_W must exceed TRIM_W+1 so a full trim fits in a second");
      end
      if (SLOW_BIT >= PRE_W - 1 || FAST_BIT >= SLOW_BIT) begin : g_bad_tap
         $error("tap bits must satisfy FAST_BIT < SLOW_BIT < PRE_W-1");
      end
      if (SECS < 2) begin : g_bad_secs
         $error("SECS must be at least 2");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [TRIM_W:0]  frz_q;
   logic [SEC_W-1:0] sec_q;
   logic             wrap;
   logic             at_last;
   logic             min_edge;

   assign min_edge = wrap && at_last;

   rtcp_prescaler #(.PRE_W(PRE_W), .TRIM_W(TRIM_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .min_edge(min_edge),
      .trim_mag(trim_mag), .trim_neg(trim_neg),
      .pre_q(pre_q), .frz_q(frz_q), .wrap(wrap)
   );

   rtcp_sec_counter #(.SECS(SECS)) u_sec (
      .clk(clk), .rst_n(rst_n), .adv(wrap),
      .sec_q(sec_q), .at_last(at_last)
   );

   rtcp_wave_sel u_wave (
      .clk(clk),
      .tap_second(pre_q[PRE_W-1]),
      .tap_slow(pre_q[SLOW_BIT]),
      .tap_fast(pre_q[FAST_BIT]),
      .rate_sel(rate_sel), .wave_en(wave_en), .on_battery(on_battery),
      .wave_out(wave_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_tick <= 1'b0;
         min_tick <= 1'b0;
      end else begin
         sec_tick <= wrap;
         min_tick <= min_edge;
      end
   end
endmodule

// File: rtl/rtcp_checker.sv
module rtcp_checker #(
   parameter int PRE_W  = 15,
   parameter int SECS   = 60,
   parameter int TRIM_W = 8,
   parameter int SEC_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TRIM_W-1:0] trim_mag,
   input logic              trim_neg,
   input logic [2:0]        rate_sel,
   input logic              wave_en,
   input logic              on_battery,
   input logic              wave_out,
   input logic              sec_tick,
   input logic              min_tick,
   input logic [PRE_W-1:0]  pre_q,
   input logic [TRIM_W:0]   frz_q,
   input logic [SEC_W-1:0]  sec_q,
   input logic              min_edge
);
   assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   assert_min_with_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |-> sec_tick);

   assert_sec_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sec_q) < SECS);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q != '0) |=> (pre_q == $past(pre_q)));

   assert_add_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (min_edge && !trim_neg) |=> (int'(frz_q) == 2 * int'($past(trim_mag))));

   assert_skip_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (min_edge && trim_neg) |=> (int'(pre_q) == 2 * int'($past(trim_mag))));

   assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wave_en || on_battery || rate_sel[2]) |-> !wave_out);
endmodule

bind rtc_trim_prescaler rtcp_checker #(
   .PRE_W(PRE_W), .SECS(SECS), .TRIM_W(TRIM_W), .SEC_W(SEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trim_mag(trim_mag), .trim_neg(trim_neg),
   .rate_sel(rate_sel), .wave_en(wave_en), .on_battery(on_battery),
   .wave_out(wave_out), .sec_tick(sec_tick), .min_tick(min_tick),
   .pre_q(pre_q), .frz_q(frz_q), .sec_q(sec_q), .min_edge(min_edge)
);

// File: tb/sim_rtc_trim_prescaler.sv
module sim_rtc_trim_prescaler;
   localparam int PRE_W  = 6;
   localparam int SECS   = 4;
   localparam int TRIM_W = 4;
   localparam int DIV    = 1 << PRE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [TRIM_W-1:0] trim_mag = '0;
   logic              trim_neg = 1'b0;
   logic [2:0]        rate_sel = 3'b000;
   logic              wave_en = 1'b1;
   logic              on_battery = 1'b0;
   logic              wave_out, sec_tick, min_tick;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #10 clk = ~clk;

   rtc_trim_prescaler #(.PRE_W(PRE_W), .SECS(SECS), .TRIM_W(TRIM_W)) u0 (
      .clk(clk), .rst_n(rst_n), .trim_mag(trim_mag), .trim_neg(trim_neg),
      .rate_sel(rate_sel), .wave_en(wave_en), .on_battery(on_battery),
      .wave_out(wave_out), .sec_tick(sec_tick), .min_tick(min_tick)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic to_sec(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!sec_tick);
   endtask

   task automatic to_rise(output int n);
      logic prev;
      prev = wave_out;
      n = 0;
      forever begin
         @(negedge clk); n++;
         if (wave_out && !prev) break;
         prev = wave_out;
      end
   endtask

   task automatic wait_min();
      do @(negedge clk); while (!min_tick);
   endtask

   // arm a trim right after a boundary, then stop on the boundary that applies it
   task automatic arm(input int mag, input bit neg);
      wait_min();
      trim_mag = TRIM_W'(mag);
      trim_neg = neg;
      wait_min();
   endtask

   task automatic t_reset_r1();
      int n;
      repeat (3) @(negedge clk);
      check("R1 sec_tick in reset", int'(sec_tick), 0);
      check("R1 min_tick in reset", int'(min_tick), 0);
      check("R1 1Hz tap low in reset", int'(wave_out), 0);
      rst_n = 1'b1;
      to_sec(n);
      check("R1 first second length", n, DIV);
   endtask

   task automatic t_period_r2();
      int n;
      to_sec(n);
      check("R2 plain second length", n, DIV);
      @(negedge clk);
      check("R2 tick is one cycle", int'(sec_tick), 0);
   endtask

   task automatic t_minute_r3();
      int secs;
      bit lone;
      wait_min();
      secs = 0;
      lone = 0;
      do begin
         @(negedge clk);
         if (sec_tick) secs++;
         if (min_tick && !sec_tick) lone = 1;
      end while (!min_tick);
      check("R3 seconds per minute", secs, SECS);
      check("R3 min_tick without sec_tick", int'(lone), 0);
   endtask

   task automatic t_trim(input string req, input int mag, input bit neg, input int exp);
      int n;
      arm(mag, neg);
      to_sec(n);
      check(req, n, exp);
   endtask

   task automatic t_sample_r7();
      int n;
      arm(0, 1'b0);
      trim_mag = 4'd5;
      trim_neg = 1'b0;
      to_sec(n);
      check("R7 mid-change not yet used", n, DIV);
      wait_min();
      to_sec(n);
      check("R7 change used at next boundary", n, DIV + 10);
   endtask

   task automatic t_taps_r8();
      int n;
      arm(0, 1'b0);
      rate_sel = 3'b000;
      wait_min();
      to_rise(n);
      check("R8 1Hz tap rises at half second", n, DIV / 2);
      rate_sel = 3'b001;
      to_rise(n);
      to_rise(n);
      check("R8 code 01 period", n, 8);
      rate_sel = 3'b010;
      to_rise(n);
      to_rise(n);
      check("R8 code 10 period", n, 4);
   endtask

   task automatic t_delay_r10();
      int n;
      rate_sel = 3'b001;
      arm(6, 1'b0);
      to_rise(n);
      check("R10 code 01 held off", n, 12 + 4);
      rate_sel = 3'b000;
      wait_min();
      to_rise(n);
      check("R10 1Hz stretched", n, 12 + DIV / 2);
      arm(6, 1'b1);
      to_rise(n);
      check("R10 1Hz shortened", n, DIV / 2 - 12);
   endtask

   task automatic t_raw_r9();
      int bad;
      rate_sel = 3'b011;
      trim_mag = 4'd7;
      trim_neg = 1'b1;
      bad = 0;
      repeat (2 * SECS * DIV) begin
         @(posedge clk); #3;
         if (wave_out !== 1'b1) bad++;
         @(negedge clk); #3;
         if (wave_out !== 1'b0) bad++;
      end
      check("R9 raw clock passthrough", bad, 0);
   endtask

   task automatic gate_window(input string req);
      int seen;
      seen = 0;
      repeat (100) begin
         @(posedge clk); #3;
         if (wave_out !== 1'b0) seen++;
         @(negedge clk); #3;
         if (wave_out !== 1'b0) seen++;
      end
      check(req, seen, 0);
   endtask

   task automatic t_gate_r11();
      @(negedge clk);
      rate_sel = 3'b011;
      wave_en = 1'b0;
      gate_window("R11 disabled pin low");
      @(negedge clk);
      wave_en = 1'b1;
      on_battery = 1'b1;
      gate_window("R11 battery mode pin low");
      @(negedge clk);
      on_battery = 1'b0;
      rate_sel = 3'b100;
      gate_window("R11 upper select bit pin low");
      @(negedge clk);
      rate_sel = 3'b000;
   endtask

   initial begin
      t_reset_r1();
      t_period_r2();
      t_minute_r3();
      t_trim("R4 added cycles", 7, 1'b0, DIV + 14);
      t_trim("R5 removed cycles", 9, 1'b1, DIV - 18);
      t_trim("R6 zero trim, sign 1", 0, 1'b1, DIV);
      t_trim("R6 zero trim, sign 0", 0, 1'b0, DIV);
      t_sample_r7();
      t_taps_r8();
      t_delay_r10();
      t_raw_r9();
      t_gate_r11();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule